// File: doc/BRIEF.md
# Interrupt Entry Stack Sequencer

This block carries out the hardware half of taking a peripheral interrupt. When a request number is offered and the global interrupt enable is set, it takes the request, tells the enable owner to clear the bit, and captures the current program counter, condition-code byte and stack pointer. It then drives a single memory port through four transfers. The first reads a pointer word from the vector table slot for the request. The second reads the handler address from the location that pointer names. The third pushes the PC onto a descending word stack. The fourth pushes the condition-code byte. It finishes with a one-cycle strobe that loads the handler address into the PC and hands back the lowered stack pointer.

The request side is a valid/ready pair. `irq_ready` is high only while the block is idle and the enable is set, so a request held with `irq_valid` simply waits, and a request offered while busy is left untouched. The memory side is a request/ready pair. The sequencer raises `mem_req` with address, write flag, byte enables and write data, and holds all of them unchanged until the memory answers with `mem_ready`. Read data is taken in the cycle `mem_ready` is high. Any number of wait cycles is allowed, including none.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is taken only in a cycle where `irq_valid`, `ie_in` and `irq_ready` are all high. `irq_ready` equals `ie_in` while the block is idle and is 0 while busy.
- R2: `ie_clr` is high for exactly the cycle in which a request is taken, and for no other cycle.
- R3: The first transfer is a read (`mem_we`=0) at byte address `irq_num` shifted left by one bit, with zero extension to the address width.
- R4: The second transfer is a read at the address held in the low `ADDR_W` bits of the first read's data. The low `ADDR_W` bits of the second read's data become `pc_next`.
- R5: The third transfer is a write with `mem_be`=2'b11 at stack pointer minus 2. Its data is the PC captured at acceptance, zero-extended to 16 bits.
- R6: The fourth transfer is a write with `mem_be`=2'b11 at stack pointer minus 4. Its data carries the condition-code byte captured at acceptance in both byte lanes. Later changes on `ccr_in`, `pc_in` and `sp_in` have no effect on the entry in progress.
- R7: In the cycle after the fourth transfer completes, `pc_load` and `sp_we` are high for one cycle, with `pc_next` holding the handler address and `sp_out` equal to the captured stack pointer minus 4. `busy` is low in the following cycle.
- R8: `busy` is high from the cycle after acceptance through the `pc_load` cycle. While it is high, new requests raise neither `ie_clr` nor `irq_ready`. While it is low, `mem_req` stays low.
- R9: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we`, `mem_be` and `mem_wdata` hold their values into the next cycle.
- R10: Words are big-endian. `mem_wdata[15:8]` and `mem_be[1]` belong to the even byte address, and `mem_wdata[7:0]` and `mem_be[0]` belong to the odd byte address.
- R11: Stack addresses wrap modulo 2^`ADDR_W`. With a captured stack pointer of 0, the pushes land at the top two words of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| irq_valid | input | 1 | Interrupt request present |
| irq_ready | output | 1 | Request can be taken this cycle |
| irq_num | input | REQ_W | Request number |
| ie_in | input | 1 | Global interrupt enable |
| ie_clr | output | 1 | Clear the global enable (acceptance cycle) |
| pc_in | input | ADDR_W | Current program counter |
| ccr_in | input | 8 | Current condition-code byte |
| sp_in | input | ADDR_W | Current stack pointer |
| busy | output | 1 | Entry sequence in progress |
| pc_load | output | 1 | Load `pc_next` into the PC |
| pc_next | output | ADDR_W | Handler address |
| sp_we | output | 1 | Write `sp_out` into the stack pointer |
| sp_out | output | ADDR_W | Lowered stack pointer |
| mem_req | output | 1 | Memory transfer request |
| mem_ready | input | 1 | Memory transfer completes this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address (even) |
| mem_be | output | 2 | Byte enables, bit 1 = even byte |
| mem_wdata | output | 16 | Write data, big-endian |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` |

## Verification
The bench builds the block with `ADDR_W`=8 and `REQ_W`=3, so the whole address space fits in a 256-byte memory model inside the bench. It sweeps every one of the eight request numbers against four stack pointers, zero among them, and against memory latencies of zero, one and two wait states. The small address width puts the wrap at zero and the truncation of the 16-bit pointer and handler words within reach of every run. It also makes the vector-slot arithmetic checkable for every request number rather than a sample of them.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  localparam int WORD_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int LANES   = WORD_W / BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_VEC_PTR  = 3'd1,
    ST_VEC_TGT  = 3'd2,
    ST_PUSH_PC  = 3'd3,
    ST_PUSH_CCR = 3'd4,
    ST_LOAD     = 3'd5
  } seq_state_t;

  function automatic logic is_bus_state(input seq_state_t s);
    return (s == ST_VEC_PTR) || (s == ST_VEC_TGT) ||
           (s == ST_PUSH_PC) || (s == ST_PUSH_CCR);
  endfunction

endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       xfer_done,
  output seq_state_t state
);

  seq_state_t state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:     if (accept)    state_d = ST_VEC_PTR;
      ST_VEC_PTR:  if (xfer_done) state_d = ST_VEC_TGT;
      ST_VEC_TGT:  if (xfer_done) state_d = ST_PUSH_PC;
      ST_PUSH_PC:  if (xfer_done) state_d = ST_PUSH_CCR;
      ST_PUSH_CCR: if (xfer_done) state_d = ST_LOAD;
      ST_LOAD:                    state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

endmodule

// File: rtl/irq_seq_ctx.sv
module irq_seq_ctx
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REQ_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              xfer_done,
  input  seq_state_t        state,
  input  logic [REQ_W-1:0]  irq_num,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [BYTE_W-1:0] ccr_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [WORD_W-1:0] rdata,
  output logic [REQ_W-1:0]  num_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [BYTE_W-1:0] ccr_q,
  output logic [ADDR_W-1:0] sp_q,
  output logic [ADDR_W-1:0] ptr_q,
  output logic [ADDR_W-1:0] tgt_q
);

  // Snapshot of the interrupted context, taken once at acceptance
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_q <= '0;
      pc_q  <= '0;
      ccr_q <= '0;
      sp_q  <= '0;
    end else if (accept) begin
      num_q <= irq_num;
      pc_q  <= pc_in;
      ccr_q <= ccr_in;
      sp_q  <= sp_in;
    end
  end

  // Results of the two vector reads
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      tgt_q <= '0;
    end else if (xfer_done) begin
      if (state == ST_VEC_PTR) ptr_q <= rdata[ADDR_W-1:0];
      if (state == ST_VEC_TGT) tgt_q <= rdata[ADDR_W-1:0];
    end
  end

endmodule

// File: rtl/irq_seq_bus.sv
module irq_seq_bus
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REQ_W  = 5
) (
  input  seq_state_t        state,
  input  logic [REQ_W-1:0]  num_q,
  input  logic [ADDR_W-1:0] pc_q,
  input  logic [BYTE_W-1:0] ccr_q,
  input  logic [ADDR_W-1:0] sp_q,
  input  logic [ADDR_W-1:0] ptr_q,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] sp_low
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / BYTE_W);

  logic [ADDR_W-1:0] sp_one;
  logic [ADDR_W-1:0] slot_addr;
  logic [WORD_W-1:0] pc_word;
  logic [WORD_W-1:0] ccr_word;

  // Word-sized descending stack, wraps at the top of the address space
  assign sp_one = sp_q - STEP;
  assign sp_low = sp_one - STEP;

  // Vector slot: request number times the word size in bytes
  assign slot_addr = ADDR_W'({num_q, 1'b0});

  assign pc_word = WORD_W'(pc_q);

  // Replicate the condition-code byte into every lane
  for (genvar g = 0; g < LANES; g++) begin : g_ccr_lane
    assign ccr_word[g*BYTE_W +: BYTE_W] = ccr_q;
  end

  always_comb begin
    mem_req   = is_bus_state(state);
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_be    = '0;
    mem_wdata = '0;
    unique case (state)
      ST_VEC_PTR: begin
        mem_addr = slot_addr;
        mem_be   = '1;
      end
      ST_VEC_TGT: begin
        mem_addr = ptr_q;
        mem_be   = '1;
      end
      ST_PUSH_PC: begin
        mem_we    = 1'b1;
        mem_addr  = sp_one;
        mem_be    = '1;
        mem_wdata = pc_word;
      end
      ST_PUSH_CCR: begin
        mem_we    = 1'b1;
        mem_addr  = sp_low;
        mem_be    = '1;
        mem_wdata = ccr_word;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REQ_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_valid,
  output logic              irq_ready,
  input  logic [REQ_W-1:0]  irq_num,
  input  logic              ie_in,
  output logic              ie_clr,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [7:0]        ccr_in,
  input  logic [ADDR_W-1:0] sp_in,
  output logic              busy,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_next,
  output logic              sp_we,
  output logic [ADDR_W-1:0] sp_out,
  output logic              mem_req,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata
);

  seq_state_t        state;
  logic              accept;
  logic              xfer_done;
  logic [REQ_W-1:0]  num_q;
  logic [ADDR_W-1:0] pc_q;
  logic [BYTE_W-1:0] ccr_q;
  logic [ADDR_W-1:0] sp_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] tgt_q;

  assign irq_ready = ie_in && (state == ST_IDLE);
  assign accept    = irq_valid && irq_ready;
  assign ie_clr    = accept;
  assign xfer_done = mem_req && mem_ready;
  assign busy      = (state != ST_IDLE);
  assign pc_load   = (state == ST_LOAD);
  assign sp_we     = pc_load;
  assign pc_next   = tgt_q;

  irq_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .xfer_done (xfer_done),
    .state     (state)
  );

  irq_seq_ctx #(.ADDR_W(ADDR_W), .REQ_W(REQ_W)) u_ctx (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .xfer_done (xfer_done),
    .state     (state),
    .irq_num   (irq_num),
    .pc_in     (pc_in),
    .ccr_in    (ccr_in),
    .sp_in     (sp_in),
    .rdata     (mem_rdata),
    .num_q     (num_q),
    .pc_q      (pc_q),
    .ccr_q     (ccr_q),
    .sp_q      (sp_q),
    .ptr_q     (ptr_q),
    .tgt_q     (tgt_q)
  );

  irq_seq_bus #(.ADDR_W(ADDR_W), .REQ_W(REQ_W)) u_bus (
    .state     (state),
    .num_q     (num_q),
    .pc_q      (pc_q),
    .ccr_q     (ccr_q),
    .sp_q      (sp_q),
    .ptr_q     (ptr_q),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .sp_low    (sp_out)
  );

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_valid,
  input logic              irq_ready,
  input logic              ie_in,
  input logic              ie_clr,
  input logic              busy,
  input logic              pc_load,
  input logic              sp_we,
  input logic              mem_req,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        mem_be,
  input logic [15:0]       mem_wdata
);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_be) && $stable(mem_wdata));

  // R2
  clr_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ie_clr |=> busy);

  // R1
  no_enable_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_in |-> !ie_clr && !irq_ready);

  // R8
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ie_clr && !irq_ready);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R7
  load_with_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> sp_we && busy && !mem_req);

  // R7
  load_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !busy && !pc_load);

endmodule

bind irq_entry_seq irq_entry_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_valid (irq_valid),
  .irq_ready (irq_ready),
  .ie_in     (ie_in),
  .ie_clr    (ie_clr),
  .busy      (busy),
  .pc_load   (pc_load),
  .sp_we     (sp_we),
  .mem_req   (mem_req),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata)
);

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb;

  localparam int AW = 8;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          irq_valid = 1'b0;
  logic          irq_ready;
  logic [RW-1:0] irq_num = '0;
  logic          ie_in = 1'b0;
  logic          ie_clr;
  logic [AW-1:0] pc_in = '0;
  logic [7:0]    ccr_in = '0;
  logic [AW-1:0] sp_in = '0;
  logic          busy, pc_load, sp_we;
  logic [AW-1:0] pc_next, sp_out;
  logic          mem_req, mem_we;
  logic          mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_be;
  logic [15:0]   mem_wdata;
  logic [15:0]   mem_rdata = '0;

  always #2 clk = ~clk;

  irq_entry_seq #(.ADDR_W(AW), .REQ_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_num(irq_num), .ie_in(ie_in), .ie_clr(ie_clr), .pc_in(pc_in),
    .ccr_in(ccr_in), .sp_in(sp_in), .busy(busy), .pc_load(pc_load),
    .pc_next(pc_next), .sp_we(sp_we), .sp_out(sp_out), .mem_req(mem_req),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Byte-wide memory model, big-endian words
  logic [7:0]  mem [0:255];
  int          lat_cfg = 0;
  int          wait_cnt = 0;
  int          nlog = 0;
  logic [AW-1:0] log_addr  [0:7];
  logic          log_we    [0:7];
  logic [15:0]   log_wdata [0:7];
  logic [1:0]    log_be    [0:7];

  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 1'b0;
      wait_cnt  = 0;
    end
    if (rst_n && mem_req) begin
      if (wait_cnt >= lat_cfg) begin
        mem_ready = 1'b1;
        if (nlog < 8) begin
          log_addr[nlog]  = mem_addr;
          log_we[nlog]    = mem_we;
          log_wdata[nlog] = mem_wdata;
          log_be[nlog]    = mem_be;
        end
        nlog++;
        if (mem_we) begin
          if (mem_be[1]) mem[mem_addr]      = mem_wdata[15:8];
          if (mem_be[0]) mem[mem_addr + 8'd1] = mem_wdata[7:0];
          mem_rdata = 16'hxxxx;
        end else begin
          mem_rdata = {mem[mem_addr], mem[mem_addr + 8'd1]};
        end
      end else begin
        wait_cnt++;
      end
    end
  end

  function automatic logic [7:0] ptr_of(input int n);
    return 8'h20 + 8'(n * 4);
  endfunction

  function automatic logic [15:0] tgt_of(input int n);
    return {8'hA0 | 8'(n), 8'h81 + 8'(n * 19)};
  endfunction

  task automatic init_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int n = 0; n < 8; n++) begin
      mem[2*n]       = 8'hEE;           // high byte dropped by the 8-bit address
      mem[2*n + 1]   = ptr_of(n);
      mem[ptr_of(n)]     = tgt_of(n)[15:8];
      mem[ptr_of(n) + 1] = tgt_of(n)[7:0];
    end
  endtask

  task automatic run_entry(input int n, input logic [7:0] sp, input int lat,
                           input logic [7:0] pc, input logic [7:0] ccr);
    logic [7:0] s2, s4;
    int guard;
    s2 = sp - 8'd2;
    s4 = sp - 8'd4;
    lat_cfg = lat;
    nlog = 0;
    @(negedge clk);
    irq_num = RW'(n); pc_in = pc; ccr_in = ccr; sp_in = sp;
    ie_in = 1'b1; irq_valid = 1'b1;
    #0.5;
    chk("R1 ready when idle and enabled", {31'd0, irq_ready}, 32'd1);
    chk("R2 clear pulse at acceptance", {31'd0, ie_clr}, 32'd1);
    @(negedge clk);
    // scramble context inputs and keep a live request pending
    pc_in = ~pc; ccr_in = ~ccr; sp_in = sp ^ 8'h55;
    guard = 0;
    while (!pc_load && guard < 40) begin
      #0.5;
      chk("R8 busy during entry", {31'd0, busy}, 32'd1);
      chk("R8 request ignored while busy", {30'd0, irq_ready, ie_clr}, 32'd0);
      @(negedge clk);
      guard++;
    end
    #0.5;
    chk("R7 load strobe seen", {31'd0, pc_load}, 32'd1);
    chk("R7 stack pointer strobe", {31'd0, sp_we}, 32'd1);
    chk("R4 handler address", {24'd0, pc_next}, {24'd0, tgt_of(n)[7:0]});
    chk("R7 R11 lowered stack pointer", {24'd0, sp_out}, {24'd0, s4});
    ie_in = 1'b0; irq_valid = 1'b0;
    @(negedge clk);
    #0.5;
    chk("R7 idle after load", {29'd0, busy, pc_load, ie_clr}, 32'd0);
    chk("R3-R6 transfer count", nlog, 32'd4);
    chk("R3 slot read address", {23'd0, log_we[0], log_addr[0]}, {24'd0, 8'(n * 2)});
    chk("R4 pointer read address", {23'd0, log_we[1], log_addr[1]}, {24'd0, ptr_of(n)});
    chk("R5 pc push", {log_be[2], log_we[2], 5'd0, log_addr[2], log_wdata[2]},
        {2'b11, 1'b1, 5'd0, s2, 8'h00, pc});
    chk("R6 ccr push", {log_be[3], log_we[3], 5'd0, log_addr[3], log_wdata[3]},
        {2'b11, 1'b1, 5'd0, s4, ccr, ccr});
    chk("R10 R11 stacked bytes", {mem[s2], mem[s2 + 8'd1], mem[s4], mem[s4 + 8'd1]},
        {8'h00, pc, ccr, ccr});
    mem[s2] = 8'h00; mem[s2 + 8'd1] = 8'h00;
    mem[s4] = 8'h00; mem[s4 + 8'd1] = 8'h00;
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] sps [0:3];
    sps[0] = 8'h00; sps[1] = 8'h80; sps[2] = 8'hF0; sps[3] = 8'h60;
    init_mem();
    repeat (3) @(negedge clk);
    #0.5;
    chk("R8 reset state", {28'd0, busy, mem_req, pc_load, sp_we}, 32'd0);
    rst_n = 1'b1;

    // enable low: request must be left alone
    @(negedge clk);
    irq_valid = 1'b1; irq_num = 3'd5; ie_in = 1'b0;
    for (int k = 0; k < 5; k++) begin
      #0.5;
      chk("R1 no take without enable", {28'd0, irq_ready, ie_clr, busy, mem_req}, 32'd0);
      @(negedge clk);
    end
    // enable high, no request
    irq_valid = 1'b0; ie_in = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #0.5;
      chk("R1 ready without request", {29'd0, irq_ready, ie_clr, busy}, 32'd4);
      @(negedge clk);
    end
    ie_in = 1'b0;

    for (int lat = 0; lat < 3; lat++)
      for (int si = 0; si < 4; si++)
        for (int n = 0; n < 8; n++)
          run_entry(n, sps[si], lat, 8'(8'h3C + n * 7 + si), 8'(8'h91 ^ (n * 5 + lat)));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule